// File: doc/BRIEF.md
# Banked RAM expansion mapper

This block translates the two top bits of a 16-bit CPU address into a physical RAM location made of a fixed base 64K page plus up to eight extra 64K expansion pages. Each 64K page holds four 16K banks. A configuration register selects one of eight window layouts and an expansion page number. For each access the block returns the physical 16K bank, the expansion page index, and a flag that says whether the access lands in expansion RAM or in the base page.

The register is written through an I/O port that is shared with other functions. A write only counts when address bit 15 is low and the top two data bits are both set. The layouts are irregular. One moves a single expansion bank into the top window. One maps a whole expansion page. One swaps a base bank into window 1 as well as using the top expansion bank. Four more let window 1 show any chosen bank of the expansion page. Video fetches bypass the register and always read the base page with the address unchanged. A build parameter models a minimal system that has one expansion page: the page field is then ignored and the page index is forced to 0.

Top module: `banked_ram_mapper`

## Requirements
- R1: A write is accepted at a rising clock edge when io_wr_n is 0, cpu_a_hi[1] (address bit 15) is 0 and io_data[7:6] is 2'b11. It stores page = io_data[5:3] and mode = io_data[2:0]. The new mapping shows on the outputs from the cycle after that edge, and the register keeps it until the next accepted write or reset.
- R2: An I/O write with address bit 15 high, or with io_data[7:6] other than 2'b11, does not change the mapping. Data on the bus while io_wr_n is 1 does not change it either.
- R3: A synchronous active-high rst clears mode and page to 0. From the next cycle every window w (w = cpu_a_hi) maps to base bank w.
- R4: In mode 000, CPU window w maps to base bank w.
- R5: In mode 001, windows 0 to 2 map to base banks 0 to 2 and window 3 maps to expansion page p, bank 3.
- R6: In mode 010, window w maps to expansion page p, bank w.
- R7: In mode 011, window 0 maps to base bank 0, window 1 to base bank 3, window 2 to base bank 2, and window 3 to expansion page p, bank 3.
- R8: In modes 1bb (mode bit 2 set), window 1 maps to expansion page p, bank bb. Windows 0, 2 and 3 map to base banks 0, 2 and 3.
- R9: When cpu_acc is 0 (video fetch), ram_bank equals cpu_a_hi, in_ext is 0 and page_idx is 0, whatever the register holds.
- R10: in_ext is 1 exactly when the access targets expansion RAM. When in_ext is 0, page_idx is 0.
- R11: With MIN_SYS = 1, page_idx is always 0 and io_data[5:3] has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_a_hi | input | 2 | CPU address bits 15..14 (the 16K window) |
| io_data | input | 8 | Data bus driven during I/O writes |
| io_wr_n | input | 1 | Active-low I/O write strobe |
| cpu_acc | input | 1 | 1 = CPU memory access, 0 = video fetch |
| ram_bank | output | 2 | Physical address bits 15..14 |
| page_idx | output | 3 | Expansion page index |
| in_ext | output | 1 | 1 = access targets expansion RAM |

## Verification
The bench aims at the swap layout, where a design that reused the window number would send window 1 to base bank 1 rather than bank 3. It also aims at the four window-1 modes, where a design that took the bank from the wrong bits would pick the wrong expansion bank. Writes that almost qualify (bit 15 set, tag 10 or 01, strobe released) are issued after a non-trivial layout is set; a decoder that checked one tag bit or ignored bit 15 would corrupt the layout. Video fetches are swept in every mode to catch a design that let the register steer them. A second instance with the minimal-system setting shows whether a stray page number leaks out.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int WIN_W  = 2;
    localparam int PAGE_W = 3;
    localparam int MODE_W = 3;
    localparam logic [1:0] SEL_TAG = 2'b11;

    typedef enum logic [MODE_W-1:0] {
        MAP_FLAT    = 3'd0,
        MAP_TOP_EXT = 3'd1,
        MAP_ALL_EXT = 3'd2,
        MAP_SWAP    = 3'd3,
        MAP_W1_B0   = 3'd4,
        MAP_W1_B1   = 3'd5,
        MAP_W1_B2   = 3'd6,
        MAP_W1_B3   = 3'd7
    } map_mode_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        map_mode_e         mode;
    } map_cfg_t;

    typedef struct packed {
        logic              ext;
        logic [PAGE_W-1:0] page;
        logic [WIN_W-1:0]  bank;
    } map_res_t;

    // Layout selection for one CPU window; page is filled in by the caller.
    function automatic map_res_t pick_bank(map_mode_e mode, logic [WIN_W-1:0] win);
        map_res_t r;
        r.ext  = 1'b0;
        r.page = '0;
        r.bank = win;
        unique case (mode)
            MAP_FLAT: ;
            MAP_TOP_EXT: r.ext = (win == 2'd3);
            MAP_ALL_EXT: r.ext = 1'b1;
            MAP_SWAP: begin
                if (win == 2'd1) r.bank = 2'd3;
                r.ext = (win == 2'd3);
            end
            default: begin
                if (win == 2'd1) begin
                    r.ext  = 1'b1;
                    r.bank = mode[1:0];
                end
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/mapper_cfg_reg.sv
module mapper_cfg_reg
    import mapper_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_n,
    input  logic     a15,
    input  logic [7:0] data,
    output map_cfg_t cfg_q
);
    logic hit;
    assign hit = !wr_n && !a15 && (data[7:6] == SEL_TAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{page: '0, mode: MAP_FLAT};
        end else if (hit) begin
            cfg_q <= '{page: data[5:3], mode: map_mode_e'(data[2:0])};
        end
    end
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
    import mapper_pkg::*;
#(
    parameter bit MIN_SYS = 1'b0
) (
    input  map_cfg_t         cfg,
    input  logic [WIN_W-1:0] win,
    input  logic             cpu_acc,
    output map_res_t         res
);
    map_res_t sel;
    logic [PAGE_W-1:0] pg;

    assign sel = pick_bank(cfg.mode, win);

    generate
        if (MIN_SYS) begin : g_min
            logic [PAGE_W-1:0] unused_pg;
            assign unused_pg = cfg.page;
            assign pg = '0;
        end else begin : g_full
            assign pg = cfg.page;
        end
    endgenerate

    always_comb begin
        if (!cpu_acc) begin
            res = '{ext: 1'b0, page: '0, bank: win};
        end else begin
            res      = sel;
            res.page = sel.ext ? pg : '0;
        end
    end
endmodule

// File: rtl/banked_ram_mapper.sv
module banked_ram_mapper
    import mapper_pkg::*;
#(
    parameter bit MIN_SYS = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cpu_a_hi,
    input  logic [7:0] io_data,
    input  logic       io_wr_n,
    input  logic       cpu_acc,
    output logic [1:0] ram_bank,
    output logic [2:0] page_idx,
    output logic       in_ext
);
    map_cfg_t cfg_q;
    map_res_t res;

    mapper_cfg_reg cfg_i (
        .clk   (clk),
        .rst   (rst),
        .wr_n  (io_wr_n),
        .a15   (cpu_a_hi[1]),
        .data  (io_data),
        .cfg_q (cfg_q)
    );

    mapper_xlate #(.MIN_SYS(MIN_SYS)) xl_i (
        .cfg     (cfg_q),
        .win     (cpu_a_hi),
        .cpu_acc (cpu_acc),
        .res     (res)
    );

    assign ram_bank = res.bank;
    assign page_idx = res.page;
    assign in_ext   = res.ext;
endmodule

// File: rtl/mapper_chk.sv
module mapper_chk
    import mapper_pkg::*;
#(
    parameter bit MIN_SYS = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cpu_a_hi,
    input logic [7:0] io_data,
    input logic       io_wr_n,
    input logic       cpu_acc,
    input map_cfg_t   cfg_q,
    input logic [1:0] ram_bank,
    input logic [2:0] page_idx,
    input logic       in_ext
);
    // R2: a write that does not qualify leaves the stored configuration alone
    assert_ignore_write_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr_n || cpu_a_hi[1] || io_data[7:6] != 2'b11) |=> $stable(cfg_q));

    // R3: one cycle after reset the layout is the identity map
    assert_reset_flat_R3: assert property (@(posedge clk)
        rst |=> (ram_bank == cpu_a_hi && !in_ext && page_idx == 3'd0));

    // R9: video fetches pass straight to the base page
    assert_video_base_R9: assert property (@(posedge clk) disable iff (rst)
        !cpu_acc |-> (ram_bank == cpu_a_hi && !in_ext && page_idx == 3'd0));

    // R10: base accesses report page 0
    assert_base_page0_R10: assert property (@(posedge clk) disable iff (rst)
        !in_ext |-> page_idx == 3'd0);

    // R4: window 0 only reaches expansion RAM in the all-expansion layout
    assert_win0_base_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_a_hi == 2'd0 && cfg_q.mode != MAP_ALL_EXT) |-> (!in_ext && ram_bank == 2'd0));

    // R1: a qualifying write shows its mode in the next cycle
    assert_write_load_R1: assert property (@(posedge clk) disable iff (rst)
        (!io_wr_n && !cpu_a_hi[1] && io_data[7:6] == 2'b11) |=> cfg_q.mode == $past(io_data[2:0]));

    // R11: minimal system never reports a non-zero page
    generate
        if (MIN_SYS) begin : g_min_chk
            assert_min_page_R11: assert property (@(posedge clk) disable iff (rst)
                page_idx == 3'd0);
        end
    endgenerate
endmodule

bind banked_ram_mapper mapper_chk #(.MIN_SYS(MIN_SYS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cpu_a_hi (cpu_a_hi),
    .io_data  (io_data),
    .io_wr_n  (io_wr_n),
    .cpu_acc  (cpu_acc),
    .cfg_q    (cfg_q),
    .ram_bank (ram_bank),
    .page_idx (page_idx),
    .in_ext   (in_ext)
);

// File: tb/banked_ram_mapper_tb_top.sv
module banked_ram_mapper_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cpu_a_hi = '0;
    logic [7:0] io_data = '0;
    logic       io_wr_n = 1'b1;
    logic       cpu_acc = 1'b1;
    logic [1:0] bank_f, bank_m;
    logic [2:0] page_f, page_m;
    logic       ext_f, ext_m;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [2:0] m_mode = '0;
    logic [2:0] m_page = '0;

    always #5 clk = ~clk;

    banked_ram_mapper #(.MIN_SYS(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cpu_a_hi(cpu_a_hi), .io_data(io_data),
        .io_wr_n(io_wr_n), .cpu_acc(cpu_acc),
        .ram_bank(bank_f), .page_idx(page_f), .in_ext(ext_f));

    banked_ram_mapper #(.MIN_SYS(1'b1)) dut_min_i (
        .clk(clk), .rst(rst), .cpu_a_hi(cpu_a_hi), .io_data(io_data),
        .io_wr_n(io_wr_n), .cpu_acc(cpu_acc),
        .ram_bank(bank_m), .page_idx(page_m), .in_ext(ext_m));

    // Expected {ext, page, bank} written from the requirements
    function automatic logic [5:0] expect_map(logic [2:0] mode, logic [2:0] page,
                                              logic [1:0] w, logic cpu, logic min_sys);
        logic e; logic [1:0] b;
        e = 1'b0; b = w;
        if (cpu) begin
            if (mode == 3'b001) e = (w == 2'd3);
            else if (mode == 3'b010) e = 1'b1;
            else if (mode == 3'b011) begin
                if (w == 2'd1) b = 2'd3;
                e = (w == 2'd3);
            end else if (mode[2] && w == 2'd1) begin
                e = 1'b1; b = mode[1:0];
            end
        end
        return {e, (e && !min_sys) ? page : 3'd0, b};
    endfunction

    function automatic string mode_tag(logic [2:0] mode);
        if (mode == 3'b000) return "R4";
        if (mode == 3'b001) return "R5";
        if (mode == 3'b010) return "R6";
        if (mode == 3'b011) return "R7";
        return "R8";
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got ext/page/bank=%b expected %b", tag, act, exp);
        end
    endtask

    // Sweep all windows for CPU and video on both instances (sampled mid-low phase)
    task automatic sweep(string tag);
        for (int w = 0; w < 4; w++) begin
            for (int c = 0; c < 2; c++) begin
                string t;
                cpu_a_hi = w[1:0];
                cpu_acc  = c[0];
                #1;
                t = (c == 0) ? "R9" : ((tag == "") ? mode_tag(m_mode) : tag);
                check(t, {ext_f, page_f, bank_f}, expect_map(m_mode, m_page, w[1:0], c[0], 1'b0));
                check((c == 0) ? "R9" : "R11", {ext_m, page_m, bank_m},
                      expect_map(m_mode, m_page, w[1:0], c[0], 1'b1));
                if (ext_f === 1'b0 && page_f !== 3'd0) check("R10", {3'b0, page_f}, 6'd0);
            end
        end
    endtask

    // One I/O write cycle: drive at negedge, edge loads, release at next negedge
    task automatic io_write(logic a15, logic [7:0] d, logic strobe);
        @(negedge clk);
        cpu_a_hi = {a15, 1'b0};
        io_data  = d;
        io_wr_n  = ~strobe;
        @(negedge clk);
        io_wr_n  = 1'b1;
        if (strobe && !a15 && d[7:6] == 2'b11) begin
            m_page = d[5:3];
            m_mode = d[2:0];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        sweep("R3");

        // R1: every mode with several pages
        for (int md = 0; md < 8; md++) begin
            for (int pg = 0; pg < 8; pg += 3) begin
                io_write(1'b0, {2'b11, pg[2:0], md[2:0]}, 1'b1);
                sweep("");
            end
        end

        // R1: mapping changes only after the edge
        io_write(1'b0, 8'hC0, 1'b1);
        @(negedge clk);
        cpu_a_hi = 2'd0; io_data = 8'hD2; io_wr_n = 1'b0; cpu_acc = 1'b1;
        #1 check("R1", {ext_f, page_f, bank_f}, 6'b0_000_00);
        @(negedge clk);
        io_wr_n = 1'b1;
        #1 check("R1", {ext_f, page_f, bank_f}, 6'b1_010_00);
        m_mode = 3'b010; m_page = 3'b010;

        // R2: near-miss writes after a swap layout
        io_write(1'b0, 8'hEB, 1'b1);
        io_write(1'b1, 8'hC2, 1'b1);  sweep("R2");
        io_write(1'b0, 8'h82, 1'b1);  sweep("R2");
        io_write(1'b0, 8'h42, 1'b1);  sweep("R2");
        io_write(1'b0, 8'hC2, 1'b0);  sweep("R2");

        // Random mix of qualifying and non-qualifying writes
        for (int i = 0; i < 300; i++) begin
            logic [7:0] d;
            logic a15, s;
            d   = 8'($urandom);
            if ($urandom % 2) d[7:6] = 2'b11;
            a15 = ($urandom % 4) == 0;
            s   = ($urandom % 5) != 0;
            io_write(a15, d, s);
            sweep("");
        end

        // R3: reset from a non-trivial layout
        io_write(1'b0, 8'hFF, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_mode = '0; m_page = '0;
        sweep("R3");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule